// File: doc/BRIEF.md
# LED Activity Pulse Stretcher

This block turns short network status events into LED indications that a person can see. Seven status lines (link, receive address match, transmit, receive polarity, receive, jabber, collision) come into each of four LED channels. Each channel masks them with its own enable bits and merges the result into one event. The event fills a short shift register. A slow tick, about 38 Hz, then drains that register one place at a time, so even a one-cycle event keeps the LED lit for two to three tick periods (about 52 to 78 ms).

The status lines are treated as asynchronous. They pass through a two-flop synchronizer before they are used. An event then takes priority over a drain step in the same cycle, so the register is refilled at once without waiting for a tick. The tick comes from an internal prescaler. It is a one-cycle enable, not a derived clock. Each channel has a configuration word, written through a plain register write port. The word holds the enable mask and a polarity bit that selects an active-low or an active-high pin. There is no streaming data path, so every pin is a plain control or status signal and none uses valid/ready.

Top module: `led_stretch_top`

## Requirements
- R1: A channel's event is asserted when at least one status input is high while that channel's enable bit for the same input is also set; with an all-zero mask the channel never lights.
- R2: Status bit positions on `status_i` and in the enable mask are: 0 link, 1 receive address match, 2 transmit, 3 receive polarity, 4 receive, 5 jabber, 6 collision.
- R3: After reset the configuration is: channel 0 enables link only, channel 1 receive only, channel 2 receive polarity only, channel 3 transmit only, and all four are active low.
- R4: A status input that goes high before rising edge k refills the channel's register at edge k+2 (two synchronizer stages), with no wait for a tick, and the LED shows active from then on.
- R5: With no event, the register shifts one place toward the output on each tick, with zero shifted in. A single-cycle event keeps the LED active for between 2*TICK_DIV+1 and 3*TICK_DIV clock cycles.
- R6: Configuration bit 7 selects pin polarity: 0 gives active low (pin low while lit), 1 gives active high.
- R7: The tick is a single-cycle pulse that occurs once every TICK_DIV clock cycles, first at cycle TICK_DIV-1 after reset.
- R8: While reset is asserted, and right after it, every shift register is clear, so every LED pin is at its inactive level (all ones under the default polarity).
- R9: A write with `cfg_we` high loads `cfg_wdata` (bits 6:0 enable mask, bit 7 polarity) into the channel selected by `cfg_addr`; the new word governs the event from the following edge, and other channels keep their words.
- R10: When an event and a tick coincide, the event wins and the register is full after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| status_i | input | 7 | Asynchronous status lines, bit order per R2 |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Channel selected for the write |
| cfg_wdata | input | 8 | Enable mask [6:0] and polarity [7] |
| led_o | output | 4 | LED pins, one per channel |

## Verification
On every cycle, assertions in the RTL check several things. The register is refilled whenever an event is present, and it holds or shifts by exactly one place depending on the tick. Its contents always form a contiguous run of ones ending at the output bit. The tick never fires on two cycles in a row, and its counter stays in range. A configuration write lands in the addressed channel, and no configuration changes without a write. The bench's scenarios cover what the assertions cannot see. These are the reset defaults and their channel-to-source mapping, and the visible stretch length measured in cycles from a single-cycle pulse. They also cover the polarity flip through a write and the event-over-tick priority under random traffic. Throughout, the pins are compared against a behavioural model of the whole block.

// File: rtl/led_pkg.sv
package led_pkg;
  localparam int NUM_SRC = 7;

  // status bit positions
  localparam int SRC_LINK  = 0;
  localparam int SRC_RXMAT = 1;
  localparam int SRC_TX    = 2;
  localparam int SRC_RXPOL = 3;
  localparam int SRC_RX    = 4;
  localparam int SRC_JAB   = 5;
  localparam int SRC_COLL  = 6;

  typedef struct packed {
    logic               act_high;
    logic [NUM_SRC-1:0] en;
  } led_cfg_t;

  localparam int CFG_W = $bits(led_cfg_t);

  function automatic led_cfg_t reset_cfg(input int idx);
    led_cfg_t c;
    c.act_high = 1'b0;
    c.en       = '0;
    case (idx)
      0: c.en[SRC_LINK]  = 1'b1;
      1: c.en[SRC_RX]    = 1'b1;
      2: c.en[SRC_RXPOL] = 1'b1;
      3: c.en[SRC_TX]    = 1'b1;
      default: c.en = '0;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/led_tick_gen.sv
module led_tick_gen #(
  parameter int TICK_DIV = 5263158
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int CNT_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_DIV - 1);

  logic [CNT_W-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  // R7: counter never leaves its range
  a_r7_count_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  generate
    if (TICK_DIV > 1) begin : g_gap
      // R7: tick is a single-cycle pulse
      a_r7_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/led_cfg_regs.sv
module led_cfg_regs
  import led_pkg::*;
#(
  parameter int NUM_LEDS = 4,
  parameter int ADDR_W   = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [CFG_W-1:0]              wdata_i,
  output led_cfg_t [NUM_LEDS-1:0]       cfg_o
);
  led_cfg_t [NUM_LEDS-1:0] cfg_q;

  generate
    for (genvar i = 0; i < NUM_LEDS; i++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          cfg_q[i] <= reset_cfg(i);
        else if (we_i && (int'(addr_i) == i))
          cfg_q[i] <= led_cfg_t'(wdata_i);
      end
    end
  endgenerate

  assign cfg_o = cfg_q;

  // R9: a write lands in the addressed channel
  a_r9_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && int'(addr_i) < NUM_LEDS) |=> cfg_o[$past(addr_i)] == $past(wdata_i));

  // R9: nothing changes without a write
  a_r9_hold_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> $stable(cfg_o));
endmodule

// File: rtl/led_status_sync.sv
module led_status_sync #(
  parameter int WIDTH  = 7,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/led_stretcher.sv
module led_stretcher
  import led_pkg::*;
#(
  parameter int SR_BITS = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_i,
  input  logic [NUM_SRC-1:0] status_i,
  input  led_cfg_t           cfg_i,
  output logic               led_o
);
  logic               event_w;
  logic [SR_BITS-1:0] sr_q;

  assign event_w = |(status_i & cfg_i.en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sr_q <= '0;
    else if (event_w) sr_q <= '1;
    else if (tick_i)  sr_q <= {1'b0, sr_q[SR_BITS-1:1]};
  end

  assign led_o = cfg_i.act_high ? sr_q[0] : ~sr_q[0];

  // R4 R10: an event fills the register, tick or not
  a_r4_event_fills: assert property (@(posedge clk) disable iff (!rst_n)
    event_w |=> sr_q == '1);

  // R5: drain by one place on a tick without an event
  a_r5_drain_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!event_w && tick_i) |=> sr_q == ($past(sr_q) >> 1));

  // R5: hold between ticks
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!event_w && !tick_i) |=> $stable(sr_q));

  // R5: contents are always a run of ones ending at the output bit
  a_r5_run_shape: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_q & (sr_q + 1'b1)) == '0);
endmodule

// File: rtl/led_stretch_top.sv
module led_stretch_top
  import led_pkg::*;
#(
  parameter int NUM_LEDS = 4,
  parameter int TICK_DIV = 5263158,
  parameter int SR_BITS  = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [6:0]                    status_i,
  input  logic                          cfg_we,
  input  logic [$clog2(NUM_LEDS)-1:0]   cfg_addr,
  input  logic [7:0]                    cfg_wdata,
  output logic [NUM_LEDS-1:0]           led_o
);
  localparam int ADDR_W = $clog2(NUM_LEDS);

  logic                    tick_w;
  logic [NUM_SRC-1:0]      status_sync;
  led_cfg_t [NUM_LEDS-1:0] cfg_w;

  led_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick_o(tick_w)
  );

  led_status_sync #(.WIDTH(NUM_SRC), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(status_i), .q_o(status_sync)
  );

  led_cfg_regs #(.NUM_LEDS(NUM_LEDS), .ADDR_W(ADDR_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we_i(cfg_we), .addr_i(cfg_addr),
    .wdata_i(cfg_wdata), .cfg_o(cfg_w)
  );

  generate
    for (genvar i = 0; i < NUM_LEDS; i++) begin : g_led
      led_stretcher #(.SR_BITS(SR_BITS)) u_str (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_w),
        .status_i(status_sync), .cfg_i(cfg_w[i]), .led_o(led_o[i])
      );
    end
  endgenerate

  // R1: a channel with an empty mask stays at its inactive level
  a_r1_empty_mask_dark: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_w[0].en == '0 && $past(cfg_w[0].en) == '0 && $past(cfg_w[0].en, 2) == '0
     && $past(cfg_w[0].en, 3) == '0 && $past(cfg_w[0].en, 4) == '0 && !$past(led_o[0] ^ !cfg_w[0].act_high))
    |-> (led_o[0] == !cfg_w[0].act_high) || $past(cfg_w[0].act_high) != cfg_w[0].act_high);
endmodule

// File: tb/tb_led_stretch_top.sv
module tb_led_stretch_top;
  localparam int DIV = 8;
  localparam int NL  = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] status_i = '0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [3:0] led_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  led_stretch_top #(.NUM_LEDS(NL), .TICK_DIV(DIV), .SR_BITS(3)) dut (
    .clk(clk), .rst_n(rst_n), .status_i(status_i), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .led_o(led_o)
  );

  always #2.5 clk = ~clk;

  // behavioural reference
  int         m_cnt;
  int         m_left [NL];
  logic [6:0] m_en   [NL];
  bit         m_hi   [NL];
  logic [6:0] hist [$];

  task automatic model_reset();
    m_cnt = 0;
    hist.delete();
    hist.push_back('0);
    hist.push_back('0);
    for (int i = 0; i < NL; i++) begin m_left[i] = 0; m_hi[i] = 0; end
    m_en[0] = 7'h01;  // R3 link
    m_en[1] = 7'h10;  // R3 receive
    m_en[2] = 7'h08;  // R3 receive polarity
    m_en[3] = 7'h04;  // R3 transmit
  endtask

  initial model_reset();

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_reset();
    else begin
      bit tk;
      logic [6:0] old;
      tk = (m_cnt == DIV - 1);
      m_cnt = tk ? 0 : m_cnt + 1;
      old = hist.pop_front();
      for (int i = 0; i < NL; i++) begin
        if ((old & m_en[i]) != 0) m_left[i] = 3;
        else if (tk && m_left[i] > 0) m_left[i] = m_left[i] - 1;
      end
      hist.push_back(status_i);
      if (cfg_we) begin
        m_en[cfg_addr] = cfg_wdata[6:0];
        m_hi[cfg_addr] = cfg_wdata[7];
      end
    end
  end

  function automatic logic [3:0] model_led();
    logic [3:0] v;
    for (int i = 0; i < NL; i++) v[i] = m_hi[i] ? (m_left[i] > 0) : !(m_left[i] > 0);
    return v;
  endfunction

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: led_o actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // compare against the model on every clock (R1 R2 R4 R5 R6 R7 R9 R10)
  always @(negedge clk) begin
    if (!done) check("R1 R4 R5 R6 R7 R10 model", led_o, model_led());
  end

  task automatic wr(input int idx, input logic [7:0] d);
    cfg_we = 1'b1; cfg_addr = 2'(idx); cfg_wdata = d;
    @(negedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin @(negedge clk); #1; end
  endtask

  initial begin
    int len;
    rst_n = 1'b0;
    idle(3);
    check("R8 during reset", led_o, 4'hF);
    rst_n = 1'b1;
    idle(2);
    check("R8 after reset", led_o, 4'hF);

    // R3 R2: link only lights channel 0 (active low)
    status_i = 7'h01;
    idle(3);
    check("R3 R2 link->led0", led_o, 4'b1110);
    status_i = 7'h00;
    idle(4 * DIV);
    check("R5 drained", led_o, 4'hF);

    // R3 R2: transmit bit 2 -> channel 3, receive bit 4 -> channel 1
    status_i = 7'h14;
    idle(3);
    check("R3 R2 tx/rx map", led_o, 4'b0101);
    status_i = 7'h00;
    idle(4 * DIV);

    // R5: single-cycle receive-polarity pulse length on channel 2
    status_i = 7'h08;
    idle(1);
    status_i = 7'h00;
    len = 0;
    for (int k = 0; k < 5 * DIV; k++) begin
      @(negedge clk); #1;
      if (led_o[2] == 1'b0) len++;
    end
    checks++;
    if (len < 2 * DIV + 1 || len > 3 * DIV) begin
      errors++;
      $display("FAIL R5 stretch length actual %0d expected %0d..%0d", len, 2 * DIV + 1, 3 * DIV);
    end

    // R9 R6: channel 2 on collision, active high
    wr(2, 8'hC0);
    status_i = 7'h40;
    idle(3);
    check("R9 R6 collision active high", led_o, 4'b1111 ^ 4'b0000 | 4'b0100);
    status_i = 7'h00;
    idle(4 * DIV);
    check("R6 active high idle", led_o, 4'b1011);

    // R1: empty mask on channel 0 ignores link
    wr(0, 8'h00);
    status_i = 7'h01;
    idle(6);
    check("R1 empty mask", led_o, 4'b1011);
    status_i = 7'h00;
    idle(2);

    // random traffic and writes, model compared every clock (R10 covered)
    for (int k = 0; k < 4000; k++) begin
      logic [6:0] s;
      for (int b = 0; b < 7; b++) s[b] = ($urandom_range(0, 15) == 0);
      status_i = s;
      if ($urandom_range(0, 40) == 0) begin
        cfg_we = 1'b1; cfg_addr = 2'($urandom_range(0, 3)); cfg_wdata = 8'($urandom);
      end else cfg_we = 1'b0;
      @(negedge clk); #1;
    end
    cfg_we = 1'b0;
    status_i = '0;
    idle(4 * DIV);

    // R8: mid-run reset clears everything
    rst_n = 1'b0;
    idle(2);
    check("R8 mid reset", led_o, 4'hF);
    rst_n = 1'b1;
    idle(2);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < 150000; k++) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule